// File: doc/BRIEF.md
# SEC-DED Read Checker with Error Capture

This block sits on the read return path of a 32-bit memory protected by seven check bits. Each 39-bit codeword that comes back is decoded combinationally into an 8-bit syndrome. The upper seven bits of the syndrome give a bit position. The LSB gives the result of an odd-parity check over the whole word. A single flipped bit is corrected before the data leaves the block. A word that cannot be corrected is flagged and passed on unaltered.

When a read is accepted and reporting for its error class is enabled, the block records the most recent error in capture registers. The record holds the access address, the access attributes, the raw data bits and the syndrome. The block also raises a sticky flag: one for single-bit corrected errors and one for non-correctable errors. Software clears each flag by writing a 1 to it. The syndrome capture register cannot be written.

Top module: `secded_rd_check`

## Requirements
- R1: A valid codeword has an odd number of ones and its position XOR is 0. It gives syndrome 0x01, `corr_o`=0 and `uncorr_o`=0, and `rd_data_o` equals the stored data.
- R2: Codeword layout: position 0 is check bit 0, the overall parity bit. Positions 1, 2, 4, 8, 16 and 32 hold check bits 1 to 6. The other positions, from 38 down to 3, hold data bits 0 up to 31. So position 3 holds data 31, 5 holds data 30, 6 holds data 29 and 7 holds data 28.
- R3: Syndrome bits [7:1] are the XOR of the indices of all set codeword bits. Syndrome bit [0] is 1 when the word has an odd number of ones.
- R4: If syndrome bit 0 is 0 and the position field is 38 or less, the word is correctable (`corr_o`=1). If the position holds a data bit, that data bit is inverted on `rd_data_o`.
- R5: A single flip of a check bit, including syndrome 0x00 (check bit 0), is reported as correctable and leaves the 32 data bits unchanged.
- R6: The word is non-correctable (`uncorr_o`=1) in two cases: syndrome bit 0 is 1 with a non-zero position, or syndrome bit 0 is 0 with a position above 38. In both cases `rd_data_o` equals the raw data bits.
- R7: Capture registers load on the clock edge of a read with `rd_valid_i`=1 in two cases: a correctable word with `cfg_rpt_sbc_i`=1, or a non-correctable word with `cfg_rpt_nce_i`=1. They load the address, attributes, raw data and syndrome, and each load overwrites the previous record.
- R8: A qualifying capture also sets `flag_sbc_o` or `flag_nce_o`. An error whose class is disabled changes neither the captures nor the flags.
- R9: The flags are sticky. A write with `reg_we_i`=1 and `reg_sel_i`=0 clears `flag_sbc_o` where `reg_wdata_i[0]`=1 and `flag_nce_o` where `reg_wdata_i[1]`=1. A set in the same cycle wins over the clear.
- R10: A write with `reg_sel_i`=1, which targets the syndrome capture, has no effect on any register.
- R11: After reset, both flags and all capture registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_valid_i | input | 1 | Read word accepted this cycle |
| rd_addr_i | input | ADDR_W | Access address |
| rd_attr_i | input | ATTR_W | Access attributes |
| rd_cw_i | input | 39 | Raw codeword from memory |
| cfg_rpt_sbc_i | input | 1 | Enable reporting of correctable errors |
| cfg_rpt_nce_i | input | 1 | Enable reporting of non-correctable errors |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0: status flags, 1: syndrome capture |
| reg_wdata_i | input | 2 | Write data, 1 clears the matching flag |
| rd_data_o | output | 32 | Corrected read data |
| synd_o | output | 8 | Live syndrome |
| corr_o | output | 1 | Current word is correctable |
| uncorr_o | output | 1 | Current word is non-correctable |
| cap_addr_o | output | ADDR_W | Captured address |
| cap_attr_o | output | ATTR_W | Captured attributes |
| cap_data_o | output | 32 | Captured raw data |
| cap_synd_o | output | 8 | Captured syndrome |
| flag_sbc_o | output | 1 | Sticky correctable-error flag |
| flag_nce_o | output | 1 | Sticky non-correctable flag |

## Verification
A bit mapped to the wrong codeword position shows up in the same cycle as a wrong corrected data bit or a wrong syndrome. It appears as soon as that position is flipped, so the bench sweeps every position one at a time. A wrong class decision, or a dropped enable, corrupts the capture registers or a flag one edge later. The record then stays visibly wrong until the next qualifying event. A broken clear or a write that leaks into the syndrome capture shows on the flag or capture outputs on the edge right after the write.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CW_W   = 39;
  localparam int unsigned POS_W  = 7;
  localparam int unsigned SYN_W  = POS_W + 1;

  typedef logic [CW_W-1:0]   cw_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef logic [SYN_W-1:0]  syn_t;

  // codeword index of data bit j: non-power-of-two slots from the top down
  function automatic int unsigned data_pos(int unsigned j);
    int unsigned n;
    data_pos = 0;
    n = DATA_W - 1;
    for (int unsigned p = 3; p < CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == j) data_pos = p;
        n--;
      end
    end
  endfunction
endpackage

// File: rtl/secded_syndrome.sv
module secded_syndrome
  import secded_pkg::*;
(
  input  cw_t  cw_i,
  output syn_t synd_o
);
  logic [POS_W-1:0] pos;

  always_comb begin
    pos = '0;
    for (int unsigned i = 0; i < CW_W; i++)
      if (cw_i[i]) pos ^= POS_W'(i);
  end

  assign synd_o = {pos, ^cw_i};
endmodule

// File: rtl/secded_correct.sv
module secded_correct
  import secded_pkg::*;
(
  input  cw_t   cw_i,
  input  syn_t  synd_i,
  output data_t raw_o,
  output data_t data_o,
  output logic  single_o,
  output logic  uncorr_o
);
  logic [POS_W-1:0] pos;
  cw_t flip;

  assign pos      = synd_i[SYN_W-1:1];
  assign single_o = !synd_i[0] && (pos < POS_W'(CW_W));
  assign uncorr_o = (synd_i[0] && pos != '0) || (!synd_i[0] && pos >= POS_W'(CW_W));

  always_comb begin
    flip = '0;
    if (single_o) flip[pos] = 1'b1;
  end

  for (genvar j = 0; j < DATA_W; j++) begin : g_extract
    localparam int unsigned P = data_pos(j);
    assign raw_o[j]  = cw_i[P];
    assign data_o[j] = cw_i[P] ^ flip[P];
  end

  always_comb begin
    if (uncorr_o) p_nce_passthru_r6: assert (data_o == raw_o);
    if (single_o) p_one_bit_fix_r4: assert ($countones(data_o ^ raw_o) <= 1);
  end
endmodule

// File: rtl/secded_capture.sv
module secded_capture
  import secded_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned ATTR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_valid_i,
  input  logic              single_i,
  input  logic              uncorr_i,
  input  logic              en_sbc_i,
  input  logic              en_nce_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ATTR_W-1:0] attr_i,
  input  data_t             raw_i,
  input  syn_t              synd_i,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [1:0]        reg_wdata_i,
  output logic [ADDR_W-1:0] cap_addr_o,
  output logic [ATTR_W-1:0] cap_attr_o,
  output data_t             cap_data_o,
  output syn_t              cap_synd_o,
  output logic              flag_sbc_o,
  output logic              flag_nce_o
);
  logic set_sbc, set_nce, clr_sbc, clr_nce, load;

  assign set_sbc = ev_valid_i && single_i && en_sbc_i;
  assign set_nce = ev_valid_i && uncorr_i && en_nce_i;
  assign load    = set_sbc || set_nce;
  // syndrome capture (sel=1) is read-only: writes there decode to nothing
  assign clr_sbc = reg_we_i && !reg_sel_i && reg_wdata_i[0];
  assign clr_nce = reg_we_i && !reg_sel_i && reg_wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_addr_o <= '0;
      cap_attr_o <= '0;
      cap_data_o <= '0;
      cap_synd_o <= '0;
    end else if (load) begin
      cap_addr_o <= addr_i;
      cap_attr_o <= attr_i;
      cap_data_o <= raw_i;
      cap_synd_o <= synd_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_sbc_o <= 1'b0;
      flag_nce_o <= 1'b0;
    end else begin
      flag_sbc_o <= set_sbc || (flag_sbc_o && !clr_sbc);
      flag_nce_o <= set_nce || (flag_nce_o && !clr_nce);
    end
  end

  p_sbc_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && single_i && en_sbc_i) |=> flag_sbc_o);
  p_nce_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && uncorr_i && en_nce_i) |=> flag_nce_o);
  p_synd_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && ((single_i && en_sbc_i) || (uncorr_i && en_nce_i)))
      |=> cap_synd_o == $past(synd_i));
  p_ro_synd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i && !load) |=> $stable(cap_synd_o));
  p_w1c_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_sel_i && reg_wdata_i[0] && !(ev_valid_i && single_i && en_sbc_i))
      |=> !flag_sbc_o);
endmodule

// File: rtl/secded_rd_check.sv
module secded_rd_check
  import secded_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned ATTR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_valid_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [ATTR_W-1:0] rd_attr_i,
  input  logic [38:0]       rd_cw_i,
  input  logic              cfg_rpt_sbc_i,
  input  logic              cfg_rpt_nce_i,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [1:0]        reg_wdata_i,
  output logic [31:0]       rd_data_o,
  output logic [7:0]        synd_o,
  output logic              corr_o,
  output logic              uncorr_o,
  output logic [ADDR_W-1:0] cap_addr_o,
  output logic [ATTR_W-1:0] cap_attr_o,
  output logic [31:0]       cap_data_o,
  output logic [7:0]        cap_synd_o,
  output logic              flag_sbc_o,
  output logic              flag_nce_o
);
  syn_t  synd;
  data_t raw;

  secded_syndrome u_syn (
    .cw_i   (rd_cw_i),
    .synd_o (synd)
  );

  secded_correct u_cor (
    .cw_i     (rd_cw_i),
    .synd_i   (synd),
    .raw_o    (raw),
    .data_o   (rd_data_o),
    .single_o (corr_o),
    .uncorr_o (uncorr_o)
  );

  secded_capture #(.ADDR_W(ADDR_W), .ATTR_W(ATTR_W)) u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ev_valid_i  (rd_valid_i),
    .single_i    (corr_o),
    .uncorr_i    (uncorr_o),
    .en_sbc_i    (cfg_rpt_sbc_i),
    .en_nce_i    (cfg_rpt_nce_i),
    .addr_i      (rd_addr_i),
    .attr_i      (rd_attr_i),
    .raw_i       (raw),
    .synd_i      (synd),
    .reg_we_i    (reg_we_i),
    .reg_sel_i   (reg_sel_i),
    .reg_wdata_i (reg_wdata_i),
    .cap_addr_o  (cap_addr_o),
    .cap_attr_o  (cap_attr_o),
    .cap_data_o  (cap_data_o),
    .cap_synd_o  (cap_synd_o),
    .flag_sbc_o  (flag_sbc_o),
    .flag_nce_o  (flag_nce_o)
  );

  assign synd_o = synd;

  always_comb begin
    p_class_excl_r4: assert (!(corr_o && uncorr_o));
    if (synd == 8'h01) p_clean_r1: assert (!corr_o && !uncorr_o);
  end
endmodule

// File: tb/secded_rd_check_bench.sv
module secded_rd_check_bench;
  localparam int AW = 32;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_valid = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [TW-1:0] rd_attr = '0;
  logic [38:0]   rd_cw = '0;
  logic          en_sbc = 1'b0, en_nce = 1'b0;
  logic          we = 1'b0, sel = 1'b0;
  logic [1:0]    wdata = '0;
  logic [31:0]   data_o, cap_data;
  logic [7:0]    synd, cap_synd;
  logic          corr, uncorr, f_sbc, f_nce;
  logic [AW-1:0] cap_addr;
  logic [TW-1:0] cap_attr;

  int checks = 0, fails = 0;
  bit running = 1'b0, done = 1'b0;

  // reference state
  logic [AW-1:0] m_addr;
  logic [TW-1:0] m_attr;
  logic [31:0]   m_data;
  logic [7:0]    m_synd;
  bit            m_sbc, m_nce;
  logic [31:0]   m_clean;   // data the stimulus meant to store

  always #2 clk = ~clk;

  secded_rd_check #(.ADDR_W(AW), .ATTR_W(TW)) u_secded_rd_check (
    .clk_i(clk), .rst_ni(rst_n), .rd_valid_i(rd_valid), .rd_addr_i(rd_addr),
    .rd_attr_i(rd_attr), .rd_cw_i(rd_cw), .cfg_rpt_sbc_i(en_sbc),
    .cfg_rpt_nce_i(en_nce), .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wdata),
    .rd_data_o(data_o), .synd_o(synd), .corr_o(corr), .uncorr_o(uncorr),
    .cap_addr_o(cap_addr), .cap_attr_o(cap_attr), .cap_data_o(cap_data),
    .cap_synd_o(cap_synd), .flag_sbc_o(f_sbc), .flag_nce_o(f_nce)
  );

  // R2 layout, computed from the slot rule
  function automatic int slot_of(int j);
    int n = 31;
    for (int p = 3; p < 39; p++) begin
      if (p != 4 && p != 8 && p != 16 && p != 32) begin
        if (n == j) return p;
        n--;
      end
    end
    return -1;
  endfunction

  function automatic logic [38:0] encode(logic [31:0] d);
    logic [38:0] c = '0;
    int x = 0;
    for (int j = 0; j < 32; j++) c[slot_of(j)] = d[j];
    for (int p = 0; p < 39; p++) if (c[p]) x ^= p;
    for (int k = 0; k < 6; k++) if (x[k]) c[1 << k] = 1'b1;
    if ((^c) == 1'b0) c[0] = 1'b1;
    return c;
  endfunction

  function automatic logic [31:0] raw_of(logic [38:0] c);
    logic [31:0] d;
    for (int j = 0; j < 32; j++) d[j] = c[slot_of(j)];
    return d;
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-cycle compare and model step
  always @(negedge clk) if (running) begin : model
    int pos, ones;
    logic [7:0] e_syn;
    bit e_corr, e_unc;
    logic [31:0] e_data, raw;
    pos = 0; ones = 0;
    for (int p = 0; p < 39; p++) if (rd_cw[p]) begin pos ^= p; ones++; end
    e_syn = {pos[6:0], ones[0]};
    e_corr = (ones[0] == 0) && (pos <= 38);
    e_unc  = (ones[0] == 1 && pos != 0) || (ones[0] == 0 && pos > 38);
    raw = raw_of(rd_cw);
    e_data = raw;
    for (int j = 0; j < 32; j++) if (e_corr && slot_of(j) == pos) e_data[j] = ~raw[j];
    chk("R3", "synd", synd, e_syn);
    chk("R4", "corr", corr, e_corr);
    chk("R6", "uncorr", uncorr, e_unc);
    chk("R4", "data", data_o, e_data);
    chk("R7", "cap_addr", cap_addr, m_addr);
    chk("R7", "cap_attr", cap_attr, m_attr);
    chk("R7", "cap_data", cap_data, m_data);
    chk("R10", "cap_synd", cap_synd, m_synd);
    chk("R9", "flag_sbc", f_sbc, m_sbc);
    chk("R9", "flag_nce", f_nce, m_nce);
    if (rd_valid && ((e_corr && en_sbc) || (e_unc && en_nce))) begin
      m_addr = rd_addr; m_attr = rd_attr; m_data = raw; m_synd = e_syn;
    end
    if (we && !sel && wdata[0]) m_sbc = 0;
    if (we && !sel && wdata[1]) m_nce = 0;
    if (rd_valid && e_corr && en_sbc) m_sbc = 1;
    if (rd_valid && e_unc && en_nce) m_nce = 1;
  end

  task automatic step(logic [38:0] cw, bit v);
    @(posedge clk); #1;
    rd_cw = cw; rd_valid = v;
    rd_addr = $urandom; rd_attr = TW'($urandom);
    we = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] d;
    logic [38:0] c;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk("R11", "flags", {f_nce, f_sbc}, 2'b00);
    chk("R11", "cap_synd", cap_synd, 8'h00);
    chk("R11", "cap_data", cap_data, 32'h0);
    m_addr = '0; m_attr = '0; m_data = '0; m_synd = '0; m_sbc = 0; m_nce = 0;
    rst_n = 1'b1;
    running = 1'b1;

    // R1 clean words
    d = 32'hDEAD_BEEF; m_clean = d;
    step(encode(d), 1'b1);
    @(negedge clk);
    chk("R1", "synd", synd, 8'h01);
    chk("R1", "data", data_o, d);

    // R2/R5 directed layout points
    en_sbc = 1'b1; en_nce = 1'b1;
    d = 32'h0;
    step(encode(d) ^ 39'(1 << 3), 1'b1);
    @(negedge clk); chk("R2", "synd pos3", synd, 8'h06);
    chk("R2", "data31 fix", data_o, 32'h0);
    step(encode(d) ^ 39'(1), 1'b1);
    @(negedge clk); chk("R5", "synd ecc0", synd, 8'h00);
    chk("R5", "data kept", data_o, 32'h0);
    step(encode(d) ^ 39'(1 << 7), 1'b1);
    @(negedge clk); chk("R2", "synd pos7", synd, 8'h0E);

    // every single-bit position
    for (int p = 0; p < 39; p++) begin
      d = $urandom; m_clean = d;
      step(encode(d) ^ (39'(1) << p), 1'b1);
      @(negedge clk); chk("R4", "fixed data", data_o, d);
    end

    // R6 double error and R10 write to syndrome capture
    d = 32'h1234_5678;
    step(encode(d) ^ 39'h3, 1'b1);
    @(negedge clk); chk("R6", "nce passthru", data_o, raw_of(encode(d) ^ 39'h3));
    step(encode(d), 1'b0);
    we = 1'b1; sel = 1'b1; wdata = 2'b11;
    @(posedge clk); #1; we = 1'b0; sel = 1'b0;
    @(negedge clk); chk("R10", "flags after ro write", {f_nce, f_sbc}, 2'b11);

    // R9 clear
    we = 1'b1; wdata = 2'b01;
    @(posedge clk); #1; we = 1'b0;
    @(negedge clk); chk("R9", "sbc cleared", {f_nce, f_sbc}, 2'b10);

    // R8 disabled class
    en_sbc = 1'b0;
    step(encode(32'h5) ^ 39'(1 << 10), 1'b1);
    step(encode(32'h5), 1'b0);
    @(negedge clk); chk("R8", "disabled sbc", f_sbc, 1'b0);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int nf;
      d = $urandom; c = encode(d);
      nf = $urandom_range(0, 3);
      for (int k = 0; k < nf; k++) c[$urandom_range(0, 38)] ^= 1'b1;
      step(c, 1'($urandom));
      en_sbc = 1'($urandom); en_nce = 1'($urandom);
      we = ($urandom_range(0, 3) == 0); sel = 1'($urandom); wdata = 2'($urandom);
    end
    step('0, 1'b0);
    @(negedge clk);
    running = 1'b0; done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule